// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Core

This block is an on-chip single-port memory with one clock and a pipelined late-write protocol. On a rising edge the block samples the address, a synchronous select, a write/read selector and one write enable per 9-bit byte lane. For a write, the data word is not present on that edge. It is presented on the following rising edge. The block keeps that word, its address and its lane mask in a one-entry posted-write buffer, and later commits it to the array when the array port is not serving a read.

A read that hits the buffered address returns a merged word. Lanes marked in the buffer's mask come from the buffer, and the other lanes come from the array. Read data comes out of a registered stage one edge after the read's address edge, together with a valid strobe. The read stream has no back-pressure. There is no ready input, and a consumer must take the word in the cycle `rd_valid` is high. The word then stays on `rdata` until the next read completes.

An output-enable input forces the data output to an idle all-zero value at once, without waiting for a clock edge. A sleep input stops the block from accepting new operations. A parameter selects a 2-lane (18-bit) or 4-lane (36-bit) word. The depth scales so that total capacity stays the same.

Top module: `lw_sram`

## Requirements
- R1: An operation is accepted on a rising edge only when `sel`=1 and `sleep`=0 on that edge. `we`=1 makes it a write and `we`=0 makes it a read.
- R2: The data of a write accepted on edge N is taken from `wdata` on edge N+1. `wdata` on any other edge has no effect on the memory.
- R3: For a read accepted on edge N, `rd_valid` is 1 and `rdata` carries the word after edge N+1. After every edge that does not complete a read, `rd_valid` is 0.
- R4: `be[i]` enables lane i, which is bits `[9i+8:9i]` of `wdata`/`rdata`. A lane whose enable was 0 keeps its previous contents, including when all enables are 0.
- R5: A read returns the latest data written to its address. This includes a read accepted on the edge where the previous write's data arrives, and a read accepted directly after that.
- R6: A cycle with `sel`=0 ignores `we`, `be` and `addr`. It leaves a buffered write intact, so that write is visible to later reads.
- R7: While `oe`=0, `rdata` is all zeros and `rdata_drive` is 0, independent of the clock. When `oe` returns to 1, the held read word shows again.
- R8: While `sleep`=1, no operation is accepted and `rd_valid` stays 0. The data of a write accepted just before sleep is still captured. Stored data and the buffered write survive sleep, and operation resumes on the first edge with `sleep`=0.
- R9: After reset, `rd_valid` is 0 and the held read word is zero. Array contents are not initialised by reset.
- R10: With `WIDE`=0 the word has 2 lanes (18 bits) and `CAP_LANES/2` addresses. With `WIDE`=1 it has 4 lanes (36 bits) and `CAP_LANES/4` addresses. Every address holds an independent word.
- R11: `rdata` does not change while no read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Synchronous select for this edge |
| we | input | 1 | 1 = write, 0 = read |
| be | input | LANES | Per-lane write enables |
| addr | input | AW | Word address |
| wdata | input | W | Write data, one edge after its address |
| oe | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Blocks new operations while high |
| rdata | output | W | Read word, zero while `oe`=0 |
| rd_valid | output | 1 | Read word completed on the last edge |
| rdata_drive | output | 1 | Output is being driven (follows `oe`) |

## Verification
Two kinds of internal fault show up at the ports. A buffered write that is lost, committed twice or committed with the wrong mask appears as a wrong lane in `rdata`. It shows on the first read of that address, which can be two edges after the write's address edge when that read follows the data edge. A fault in the forwarding compare appears only when a read lands on the buffered address before a commit, so the bench interleaves reads and writes to the same address. Stage or sleep faults show as a `rd_valid` pulse out of its one-edge slot.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;
  localparam int LANE_W = 9;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/lw_sram_ctrl.sv
// Registers the controls that are sampled together on each edge.
module lw_sram_ctrl
  import lw_sram_pkg::*;
#(
  parameter int LANES = 2,
  parameter int AW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             we,
  input  logic [LANES-1:0] be,
  input  logic [AW-1:0]    addr,
  input  logic             sleep,
  output op_e              stg_op,
  output logic [AW-1:0]    stg_addr,
  output logic [LANES-1:0] stg_be
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_op   <= OP_IDLE;
      stg_addr <= '0;
      stg_be   <= '0;
    end else if (sel && !sleep) begin
      stg_op   <= we ? OP_WRITE : OP_READ;
      stg_addr <= addr;
      stg_be   <= be;
    end else begin
      stg_op   <= OP_IDLE;
    end
  end
endmodule

// File: rtl/lw_sram_wbuf.sv
// One-entry posted-write buffer: commit rule and read forwarding.
module lw_sram_wbuf
  import lw_sram_pkg::*;
#(
  parameter int  LANES = 2,
  parameter int  AW    = 5,
  localparam int W     = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  op_e              stg_op,
  input  logic [AW-1:0]    stg_addr,
  input  logic [LANES-1:0] stg_be,
  input  logic [W-1:0]     wdata,
  input  logic             sleep,
  input  logic [W-1:0]     arr_word,
  output logic             cm_en,
  output logic [AW-1:0]    cm_addr,
  output logic [LANES-1:0] cm_be,
  output logic [W-1:0]     cm_data,
  output logic [W-1:0]     rd_word
);
  logic             pend_vld;
  logic [AW-1:0]    pend_addr;
  logic [LANES-1:0] pend_be;
  logic [W-1:0]     pend_data;
  logic             hit;

  // The port is free unless a read is using it. An incoming write always
  // pushes the older entry out first. Sleep holds an entry in place.
  assign cm_en   = pend_vld &&
                   ((stg_op == OP_WRITE) || (stg_op == OP_IDLE && !sleep));
  assign cm_addr = pend_addr;
  assign cm_be   = pend_be;
  assign cm_data = pend_data;
  assign hit     = pend_vld && (pend_addr == stg_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld  <= 1'b0;
      pend_addr <= '0;
      pend_be   <= '0;
      pend_data <= '0;
    end else if (stg_op == OP_WRITE) begin
      pend_vld  <= 1'b1;
      pend_addr <= stg_addr;
      pend_be   <= stg_be;
      pend_data <= wdata;
    end else if (cm_en) begin
      pend_vld  <= 1'b0;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_fwd
    assign rd_word[g*LANE_W +: LANE_W] = (hit && pend_be[g]) ?
        pend_data[g*LANE_W +: LANE_W] : arr_word[g*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/lw_sram_array.sv
// Storage with per-lane write masking and an asynchronous read port.
module lw_sram_array
  import lw_sram_pkg::*;
#(
  parameter int  LANES = 2,
  parameter int  DEPTH = 32,
  parameter int  AW    = 5,
  localparam int W     = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    waddr,
  input  logic [LANES-1:0] wbe,
  input  logic [W-1:0]     wdata,
  input  logic [AW-1:0]    raddr,
  output logic [W-1:0]     rword
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int i = 0; i < LANES; i++) begin
        if (wbe[i]) mem[waddr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
      end
    end
  end

  assign rword = mem[raddr];
endmodule

// File: rtl/lw_sram.sv
module lw_sram
  import lw_sram_pkg::*;
#(
  parameter bit  WIDE      = 1'b0,
  parameter int  CAP_LANES = 64,
  localparam int LANES     = WIDE ? 4 : 2,
  localparam int W         = LANES * LANE_W,
  localparam int DEPTH     = CAP_LANES / LANES,
  localparam int AW        = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             we,
  input  logic [LANES-1:0] be,
  input  logic [AW-1:0]    addr,
  input  logic [W-1:0]     wdata,
  input  logic             oe,
  input  logic             sleep,
  output logic [W-1:0]     rdata,
  output logic             rd_valid,
  output logic             rdata_drive
);
  op_e              stg_op;
  logic [AW-1:0]    stg_addr;
  logic [LANES-1:0] stg_be;
  logic             cm_en;
  logic [AW-1:0]    cm_addr;
  logic [LANES-1:0] cm_be;
  logic [W-1:0]     cm_data;
  logic [W-1:0]     arr_word;
  logic [W-1:0]     rd_word;
  logic [W-1:0]     out_q;
  logic             vld_q;

  lw_sram_ctrl #(.LANES(LANES), .AW(AW)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .sel(sel), .we(we), .be(be), .addr(addr),
    .sleep(sleep), .stg_op(stg_op), .stg_addr(stg_addr), .stg_be(stg_be)
  );

  lw_sram_wbuf #(.LANES(LANES), .AW(AW)) wbuf_i (
    .clk(clk), .rst_n(rst_n), .stg_op(stg_op), .stg_addr(stg_addr),
    .stg_be(stg_be), .wdata(wdata), .sleep(sleep), .arr_word(arr_word),
    .cm_en(cm_en), .cm_addr(cm_addr), .cm_be(cm_be), .cm_data(cm_data),
    .rd_word(rd_word)
  );

  lw_sram_array #(.LANES(LANES), .DEPTH(DEPTH), .AW(AW)) array_i (
    .clk(clk), .wr_en(cm_en), .waddr(cm_addr), .wbe(cm_be), .wdata(cm_data),
    .raddr(stg_addr), .rword(arr_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= (stg_op == OP_READ);
      if (stg_op == OP_READ) out_q <= rd_word;
    end
  end

  assign rdata       = oe ? out_q : '0;
  assign rdata_drive = oe;
  assign rd_valid    = vld_q;
endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk #(
  parameter int LANES = 2,
  parameter int AW    = 5,
  parameter int W     = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel,
  input logic             we,
  input logic [LANES-1:0] be,
  input logic [AW-1:0]    addr,
  input logic             oe,
  input logic             sleep,
  input logic [W-1:0]     rdata,
  input logic             rd_valid,
  input logic             rdata_drive
);
  assert_read_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !we && !sleep) |-> ##2 rd_valid);

  assert_no_stray_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && !we && !sleep) |-> ##2 !rd_valid);

  assert_sleep_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> ##2 !rd_valid);

  assert_hold_between_reads_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && $past(oe) && !rd_valid) |-> $stable(rdata));

  assert_oe_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> (rdata == '0 && !rdata_drive));
endmodule

bind lw_sram lw_sram_chk #(.LANES(LANES), .AW(AW), .W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .sel(sel), .we(we), .be(be), .addr(addr),
  .oe(oe), .sleep(sleep), .rdata(rdata), .rd_valid(rd_valid),
  .rdata_drive(rdata_drive)
);

// File: tb/lw_sram_tb_top.sv
module lw_sram_tb_top;
  localparam int DEPTH = 32;
  localparam int W     = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel = 1'b0, we = 1'b0, oe = 1'b1, sleep = 1'b0;
  logic [1:0]    be = '0;
  logic [4:0]    addr = '0;
  logic [W-1:0]  wdata = '0;
  logic [W-1:0]  rdata;
  logic          rd_valid, rdata_drive;

  int errors = 0;
  int checks = 0;

  logic [W-1:0] model [DEPTH];
  logic         pw_v = 1'b0;
  logic [4:0]   pw_addr;
  logic [1:0]   pw_be;
  logic [W-1:0] pw_data;
  logic         rv_prev = 1'b0;
  logic [W-1:0] exp_prev = '0;
  logic [W-1:0] last_rd = '0;
  string        tag_prev = "";

  always #5 clk = ~clk;

  lw_sram #(.WIDE(1'b0), .CAP_LANES(64)) dut_i (
    .clk(clk), .rst_n(rst_n), .sel(sel), .we(we), .be(be), .addr(addr),
    .wdata(wdata), .oe(oe), .sleep(sleep), .rdata(rdata),
    .rd_valid(rd_valid), .rdata_drive(rdata_drive)
  );

  function automatic logic [W-1:0] pat(input int a, input int p);
    return W'((a * 7919 + p * 40503 + 3) ^ (a << 9));
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock of stimulus, entered and left at a falling edge.
  task automatic step(input logic s, input logic w, input logic [1:0] b,
                      input logic [4:0] a, input logic [W-1:0] d,
                      input logic slp, input string tag);
    logic         acc;
    logic [W-1:0] exp_now;
    if (pw_v) begin
      wdata = pw_data;
      for (int l = 0; l < 2; l++)
        if (pw_be[l]) model[pw_addr][l*9 +: 9] = pw_data[l*9 +: 9];
    end else begin
      wdata = ~d ^ 18'h2A5A5;  // R2: data on a non-data edge must be ignored
    end
    acc     = s && !slp;
    exp_now = model[a];
    sel = s; we = w; be = b; addr = a; sleep = slp;
    @(posedge clk);
    @(negedge clk);
    check({tag_prev, " R3 rd_valid"}, W'(rd_valid), W'(rv_prev));
    if (rv_prev) begin
      check(tag_prev, rdata, exp_prev);
      last_rd = exp_prev;
    end else begin
      check("R11 hold", rdata, last_rd);
    end
    rv_prev  = acc && !w;
    exp_prev = exp_now;
    tag_prev = tag;
    pw_v     = acc && w;
    pw_addr  = a;
    pw_be    = b;
    pw_data  = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 2'b00, 5'd0, '0, 1'b0, "idle");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 reset rd_valid", W'(rd_valid), '0);
    check("R9 reset rdata", rdata, '0);

    // R10: fill every address with a distinct full word, then read back
    for (int a = 0; a < DEPTH; a++) step(1'b1, 1'b1, 2'b11, 5'(a), pat(a, 0), 1'b0, "R10 fill");
    idle(1);
    for (int a = 0; a < DEPTH; a++) step(1'b1, 1'b0, 2'b00, 5'(a), '0, 1'b0, "R10 sweep read");
    idle(2);

    // R4 R5: partial-lane write followed at once by a read of the same address
    for (int a = 0; a < DEPTH; a++) begin
      step(1'b1, 1'b1, 2'(a % 4), 5'(a), pat(a, 1), 1'b0, "R4 mask write");
      step(1'b1, 1'b0, 2'b00, 5'(a), '0, 1'b0, "R5 forward read");
    end
    idle(2);

    // R5: two writes to one address, then reads on consecutive edges
    for (int a = 0; a < DEPTH; a += 5) begin
      step(1'b1, 1'b1, 2'b01, 5'(a), pat(a, 2), 1'b0, "R5 w1");
      step(1'b1, 1'b1, 2'b10, 5'(a), pat(a, 3), 1'b0, "R5 w2");
      step(1'b1, 1'b0, 2'b00, 5'(a), '0, 1'b0, "R5 merged read a");
      step(1'b1, 1'b0, 2'b00, 5'(a), '0, 1'b0, "R5 merged read b");
    end
    idle(2);

    // R4: all lanes disabled leaves the word unchanged
    step(1'b1, 1'b1, 2'b00, 5'd9, pat(9, 7), 1'b0, "R4 empty mask");
    step(1'b1, 1'b0, 2'b00, 5'd9, '0, 1'b0, "R4 empty mask read");
    idle(2);

    // R6: deselected cycles with write controls set, buffered write kept
    step(1'b1, 1'b1, 2'b11, 5'd3, pat(3, 8), 1'b0, "R6 write");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 2'b11, 5'd5, pat(5, 9), 1'b0, "R6 deselect");
    step(1'b1, 1'b0, 2'b00, 5'd3, '0, 1'b0, "R6 read kept");
    step(1'b1, 1'b0, 2'b00, 5'd5, '0, 1'b0, "R6 read untouched");
    idle(2);

    // R8: in-flight write across sleep, ignored operations while asleep
    step(1'b1, 1'b1, 2'b11, 5'd7, pat(7, 10), 1'b0, "R8 write");
    step(1'b1, 1'b1, 2'b11, 5'd8, pat(8, 10), 1'b1, "R8 sleep write");
    step(1'b1, 1'b0, 2'b00, 5'd7, '0, 1'b1, "R8 sleep read");
    step(1'b0, 1'b0, 2'b00, 5'd0, '0, 1'b1, "R8 sleep idle");
    step(1'b1, 1'b0, 2'b00, 5'd7, '0, 1'b0, "R8 resume read 7");
    step(1'b1, 1'b0, 2'b00, 5'd8, '0, 1'b0, "R8 resume read 8");
    idle(2);

    // R7: output enable acts without a clock edge
    oe = 1'b0;
    #1;
    check("R7 oe low rdata", rdata, '0);
    check("R7 oe low drive", W'(rdata_drive), '0);
    oe = 1'b1;
    #1;
    check("R7 oe high rdata", rdata, last_rd);
    check("R7 oe high drive", W'(rdata_drive), W'(1));
    @(negedge clk);

    // R1 R2: final sweep reads confirm nothing stray was written
    for (int a = 0; a < DEPTH; a++) step(1'b1, 1'b0, 2'b00, 5'(a), '0, 1'b0, "R1 R2 final read");
    idle(2);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule